// File: doc/BRIEF.md
# Register Bus Contribution Resolver

This block decodes one 16-bit instruction word that holds a separate action field for each of five registers: the program counter, the accumulator, two index registers and the stack pointer. All five fields are decoded together, so one instruction can run several independent register actions. The memory cycle type is not coded directly. It follows from the registers that request the address adder and the internal data bus.

The internal address is the modular sum of every address term put forward by a register. A register that does not address contributes zero. The valid-address strobe rises when any register addresses. The read/write strobe falls when any register drives the data bus. When no register addresses, a value moves from one register to another over the internal bus and no memory cycle takes place. The accumulator and the two index registers share one unit design. That unit can drive, load, increment, decrement, clear and address, and it keeps its own zero and carry flags.

Top module: `bus_merge_core`

## Requirements
- R1: The instruction fields are: program counter at bits 15:12, accumulator at 11:9, index X at 8:6, index Y at 5:3, stack at 2:0. All five act in the same cycle.
- R2: `mem_addr` is the sum modulo 2^16 of the address terms from every addressing register. A non-addressing register adds zero.
- R3: `mem_vma` is 1 exactly when at least one register addresses in the current instruction.
- R4: `mem_rnw` is 0 exactly when at least one register drives the internal bus.
- R5: `int_bus` carries `mem_rdata` when `mem_vma`=1 and `mem_rnw`=1. Otherwise it carries the driving register's value, or 0 when nothing drives. Read data is ignored outside read cycles.
- R6: Accumulator/index code 4 loads the register from `int_bus` at the clock edge. Its zero flag becomes (bus==0) and its carry flag is unchanged.
- R7: Accumulator/index code 2 increments the register, and code 3 decrements it. Carry records the wrap out of 0xFFFF or the borrow below 0. Zero reflects the new value.
- R8: Accumulator/index code 6 addresses with the register value. Code 7 does the same and then increments the register, with the code 2 flag rules.
- R9: Accumulator/index code 1 drives the register onto `int_bus`. Code 5 clears the register, sets zero and clears carry. Code 0 holds.
- R10: Program counter codes: 1 addresses with P, 2 drives P, 3 loads P from the bus, 4 increments P, and any other value holds.
- R11: Stack codes: 1 addresses with S and then increments S, 2 addresses with S-1 and decrements S, 3 loads S from the bus, 4 drives S, and any other value holds.
- R12: While `rst_n` is low, all registers and flags are 0.
- R13: Only one register may drive the internal bus in an instruction. A checker flags any instruction that breaks this rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 16 | Instruction word with five action fields |
| mem_rdata | input | 16 | Memory read data |
| mem_addr | output | 16 | Summed internal address |
| mem_vma | output | 1 | Valid memory address |
| mem_rnw | output | 1 | 1 = read, 0 = write |
| int_bus | output | 16 | Internal data bus (also write data) |
| pc_q | output | 16 | Program counter |
| acc_q | output | 16 | Accumulator |
| idx_x_q | output | 16 | Index X |
| idx_y_q | output | 16 | Index Y |
| sp_q | output | 16 | Stack pointer |
| reg_zero | output | 3 | Zero flags: bit0 accumulator, bit1 X, bit2 Y |
| reg_carry | output | 3 | Carry flags, same bit order |

## Verification
The hardest state to reach is an address formed from three or more terms at once, or one that wraps past 0xFFFF. Both need nonzero register contents, and those contents can only be built through earlier instructions. The stimulus first loads an index register from memory while popping the stack. It then combines index X, index Y and a stack pop in a single address. Later it loads the accumulator with 0xFFF8 and adds index X to it, so the sum wraps. Bus-only transfers are placed alongside read data that the design must ignore.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  // accumulator / index unit actions
  typedef enum logic [2:0] {
    G_NOP = 3'd0, G_DRIVE = 3'd1, G_INC = 3'd2, G_DEC = 3'd3,
    G_LOAD = 3'd4, G_CLR = 3'd5, G_PROJ = 3'd6, G_PROJ_INC = 3'd7
  } gen_act_e;

  // program counter actions
  typedef enum logic [3:0] {
    P_NOP = 4'd0, P_PROJ = 4'd1, P_DRIVE = 4'd2, P_LOAD = 4'd3, P_INC = 4'd4
  } pc_act_e;

  // stack pointer actions
  typedef enum logic [2:0] {
    S_NOP = 3'd0, S_POP = 3'd1, S_PUSH = 3'd2, S_LOAD = 3'd3, S_DRIVE = 3'd4
  } sp_act_e;
endpackage

// File: rtl/bmr_reg_unit.sv
module bmr_reg_unit #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    act,
  input  logic [DW-1:0] bus,
  output logic [DW-1:0] q,
  output logic          zf,
  output logic          cf,
  output logic [DW-1:0] addr_term,
  output logic [DW-1:0] data_term,
  output logic          proj,
  output logic          drv
);
  import bmr_pkg::*;

  logic [DW:0] inc_w, dec_w;

  always_comb begin
    inc_w     = {1'b0, q} + {{DW{1'b0}}, 1'b1};
    dec_w     = {1'b0, q} - {{DW{1'b0}}, 1'b1};
    proj      = (act == G_PROJ) || (act == G_PROJ_INC);
    drv       = (act == G_DRIVE);
    addr_term = proj ? q : '0;
    data_term = drv ? q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q  <= '0;
      zf <= 1'b0;
      cf <= 1'b0;
    end else begin
      case (act)
        G_INC, G_PROJ_INC: begin
          q  <= inc_w[DW-1:0];
          cf <= inc_w[DW];
          zf <= (inc_w[DW-1:0] == '0);
        end
        G_DEC: begin
          q  <= dec_w[DW-1:0];
          cf <= dec_w[DW];
          zf <= (dec_w[DW-1:0] == '0);
        end
        G_LOAD: begin
          q  <= bus;
          zf <= (bus == '0);
        end
        G_CLR: begin
          q  <= '0;
          zf <= 1'b1;
          cf <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bmr_ptr_unit.sv
module bmr_ptr_unit #(
  parameter int DW    = 16,
  parameter bit STACK = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    act,
  input  logic [DW-1:0] bus,
  output logic [DW-1:0] q,
  output logic [DW-1:0] addr_term,
  output logic [DW-1:0] data_term,
  output logic          proj,
  output logic          drv
);
  import bmr_pkg::*;

  logic [DW-1:0] nxt, aval;

  generate
    if (STACK) begin : g_stack
      always_comb begin
        nxt  = q;
        aval = q;
        proj = 1'b0;
        drv  = 1'b0;
        if (act[3] == 1'b0) begin
          case (act[2:0])
            S_POP:   begin proj = 1'b1; nxt = q + 1'b1; end
            S_PUSH:  begin proj = 1'b1; aval = q - 1'b1; nxt = q - 1'b1; end
            S_LOAD:  nxt = bus;
            S_DRIVE: drv = 1'b1;
            default: ;
          endcase
        end
      end
    end else begin : g_pc
      always_comb begin
        nxt  = q;
        aval = q;
        proj = 1'b0;
        drv  = 1'b0;
        case (act)
          P_PROJ:  proj = 1'b1;
          P_DRIVE: drv = 1'b1;
          P_LOAD:  nxt = bus;
          P_INC:   nxt = q + 1'b1;
          default: ;
        endcase
      end
    end
  endgenerate

  assign addr_term = proj ? aval : '0;
  assign data_term = drv ? q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/bmr_resolver.sv
module bmr_resolver #(
  parameter int DW = 16,
  parameter int N  = 5
) (
  input  logic [N-1:0][DW-1:0] addr_terms,
  input  logic [N-1:0][DW-1:0] data_terms,
  input  logic [N-1:0]         proj_vec,
  input  logic [N-1:0]         drv_vec,
  input  logic [DW-1:0]        mem_rdata,
  output logic [DW-1:0]        addr,
  output logic                 vma,
  output logic                 rnw,
  output logic [DW-1:0]        bus
);
  function automatic logic [DW-1:0] sum_terms(input logic [N-1:0][DW-1:0] t);
    logic [DW-1:0] s;
    s = '0;
    for (int i = 0; i < N; i++) s = s + t[i];
    return s;
  endfunction

  function automatic logic [DW-1:0] merge_drivers(input logic [N-1:0][DW-1:0] t);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < N; i++) m = m | t[i];
    return m;
  endfunction

  always_comb begin
    addr = sum_terms(addr_terms);
    vma  = |proj_vec;
    rnw  = ~(|drv_vec);
    bus  = (vma && rnw) ? mem_rdata : merge_drivers(data_terms);
  end
endmodule

// File: rtl/bus_merge_core.sv
module bus_merge_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] instr,
  input  logic [15:0] mem_rdata,
  output logic [15:0] mem_addr,
  output logic        mem_vma,
  output logic        mem_rnw,
  output logic [15:0] int_bus,
  output logic [15:0] pc_q,
  output logic [15:0] acc_q,
  output logic [15:0] idx_x_q,
  output logic [15:0] idx_y_q,
  output logic [15:0] sp_q,
  output logic [2:0]  reg_zero,
  output logic [2:0]  reg_carry
);
  localparam int DW     = 16;
  localparam int NGEN   = 3;
  localparam int NUNITS = NGEN + 2;
  localparam int PC_IDX = NGEN;
  localparam int SP_IDX = NGEN + 1;

  logic [NUNITS-1:0][DW-1:0] addr_terms, data_terms;
  logic [NUNITS-1:0]         proj_vec, drv_vec;
  logic [DW-1:0]             bus_w;
  logic [NGEN-1:0][DW-1:0]   gen_q;

  // accumulator (0), index X (1), index Y (2): fields at 11:9, 8:6, 5:3
  generate
    for (genvar i = 0; i < NGEN; i++) begin : g_gen
      bmr_reg_unit #(.DW(DW)) i_unit (
        .clk(clk), .rst_n(rst_n),
        .act(instr[11-3*i -: 3]), .bus(bus_w),
        .q(gen_q[i]), .zf(reg_zero[i]), .cf(reg_carry[i]),
        .addr_term(addr_terms[i]), .data_term(data_terms[i]),
        .proj(proj_vec[i]), .drv(drv_vec[i])
      );
    end
  endgenerate

  bmr_ptr_unit #(.DW(DW), .STACK(1'b0)) i_pc (
    .clk(clk), .rst_n(rst_n), .act(instr[15:12]), .bus(bus_w),
    .q(pc_q), .addr_term(addr_terms[PC_IDX]), .data_term(data_terms[PC_IDX]),
    .proj(proj_vec[PC_IDX]), .drv(drv_vec[PC_IDX])
  );

  bmr_ptr_unit #(.DW(DW), .STACK(1'b1)) i_sp (
    .clk(clk), .rst_n(rst_n), .act({1'b0, instr[2:0]}), .bus(bus_w),
    .q(sp_q), .addr_term(addr_terms[SP_IDX]), .data_term(data_terms[SP_IDX]),
    .proj(proj_vec[SP_IDX]), .drv(drv_vec[SP_IDX])
  );

  bmr_resolver #(.DW(DW), .N(NUNITS)) i_res (
    .addr_terms(addr_terms), .data_terms(data_terms),
    .proj_vec(proj_vec), .drv_vec(drv_vec), .mem_rdata(mem_rdata),
    .addr(mem_addr), .vma(mem_vma), .rnw(mem_rnw), .bus(bus_w)
  );

  assign int_bus = bus_w;
  assign acc_q   = gen_q[0];
  assign idx_x_q = gen_q[1];
  assign idx_y_q = gen_q[2];
endmodule

// File: rtl/bmr_checker.sv
module bmr_checker #(
  parameter int DW = 16,
  parameter int N  = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   instr,
  input logic [N-1:0]  drv_vec,
  input logic [DW-1:0] bus,
  input logic [DW-1:0] mem_rdata,
  input logic          mem_vma,
  input logic          mem_rnw,
  input logic [DW-1:0] acc_q,
  input logic [DW-1:0] idx_x_q,
  input logic [DW-1:0] sp_q
);
  p_single_driver_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(drv_vec) <= 1);

  p_read_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_vma && mem_rnw) |-> bus == mem_rdata);

  p_load_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[11:9] == 3'd4) |=> acc_q == $past(bus));

  p_inc_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[8:6] == 3'd2) |=> idx_x_q == DW'($past(idx_x_q) + 1'b1));

  p_push_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[2:0] == 3'd2) |=> sp_q == DW'($past(sp_q) - 1'b1));
endmodule

bind bus_merge_core bmr_checker #(.DW(16), .N(5)) i_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .drv_vec(drv_vec), .bus(bus_w),
  .mem_rdata(mem_rdata), .mem_vma(mem_vma), .mem_rnw(mem_rnw),
  .acc_q(acc_q), .idx_x_q(idx_x_q), .sp_q(sp_q)
);

// File: tb/test_bus_merge_core.sv
module test_bus_merge_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] instr = 16'h0000, mem_rdata = 16'h0000;
  logic [15:0] mem_addr, int_bus, pc_q, acc_q, idx_x_q, idx_y_q, sp_q;
  logic mem_vma, mem_rnw;
  logic [2:0] reg_zero, reg_carry;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  bus_merge_core i_bus_merge_core (
    .clk(clk), .rst_n(rst_n), .instr(instr), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_vma(mem_vma), .mem_rnw(mem_rnw), .int_bus(int_bus),
    .pc_q(pc_q), .acc_q(acc_q), .idx_x_q(idx_x_q), .idx_y_q(idx_y_q), .sp_q(sp_q),
    .reg_zero(reg_zero), .reg_carry(reg_carry)
  );

  // {instr, rdata, exp_addr, exp_vma, exp_rnw, exp_bus}
  localparam logic [65:0] VEC [8] = '{
    {16'h0101, 16'h0010, 16'h0000, 1'b1, 1'b1, 16'h0010}, // pop S, load X
    {16'h0990, 16'h1234, 16'h0010, 1'b1, 1'b1, 16'h1234}, // X addr, load A, inc Y
    {16'h09B1, 16'h0000, 16'h0012, 1'b1, 1'b1, 16'h0000}, // X+Y+S sum
    {16'h0060, 16'hBEEF, 16'h0000, 1'b0, 1'b0, 16'h0010}, // X -> Y, no memory
    {16'h000A, 16'h0000, 16'h0001, 1'b1, 1'b0, 16'h0010}, // push Y
    {16'h0000, 16'hBEEF, 16'h0000, 1'b0, 1'b1, 16'h0000}, // idle
    {16'h1800, 16'hFFFF, 16'h0000, 1'b1, 1'b1, 16'hFFFF}, // P addr, load A
    {16'h0400, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0000}  // inc A wraps
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] ins, input logic [15:0] rd);
    @(negedge clk);
    instr = ins;
    mem_rdata = rd;
    #3;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #10;
    // R12 reset state
    chk("R12 acc", acc_q, 0); chk("R12 x", idx_x_q, 0); chk("R12 y", idx_y_q, 0);
    chk("R12 pc", pc_q, 0); chk("R12 sp", sp_q, 0);
    chk("R12 flags", {reg_zero, reg_carry}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 table walk
    for (int i = 0; i < 8; i++) begin
      apply(VEC[i][65:50], VEC[i][49:34]);
      chk("R2 addr", mem_addr, VEC[i][33:18]);
      chk("R3 vma", mem_vma, VEC[i][17]);
      chk("R4 rnw", mem_rnw, VEC[i][16]);
      chk("R5 bus", int_bus, VEC[i][15:0]);
      tick();
    end
    // R1 R6 R7 R9 R11 state after table
    chk("R7 acc wrapped", acc_q, 16'h0000);
    chk("R7 acc zero/carry", {reg_zero[0], reg_carry[0]}, 2'b11);
    chk("R6 x loaded", idx_x_q, 16'h0010);
    chk("R9 y via bus", idx_y_q, 16'h0010);
    chk("R11 sp after pops/push", sp_q, 16'h0001);
    chk("R10 pc held", pc_q, 16'h0000);

    // R6 load keeps carry, then R2 wrap of sum
    apply(16'h0801, 16'hFFF8);
    chk("R11 pop addr", mem_addr, 16'h0001);
    tick();
    chk("R6 acc", acc_q, 16'hFFF8);
    chk("R6 flags", {reg_zero[0], reg_carry[0]}, 2'b01);
    apply(16'h0D80, 16'h5555);
    chk("R2 wrap", mem_addr, 16'h0008);
    chk("R5 read", int_bus, 16'h5555);
    tick();

    // R8 address with post-increment, R10 pc increment and drive
    apply(16'h41C0, 16'h0000);
    chk("R8 addr", mem_addr, 16'h0010);
    chk("R8 vma", mem_vma, 1'b1);
    tick();
    chk("R8 x post inc", idx_x_q, 16'h0011);
    chk("R10 pc inc", pc_q, 16'h0001);
    apply(16'h2000, 16'hBEEF);
    chk("R10 drive bus", int_bus, 16'h0001);
    chk("R4 write", {mem_vma, mem_rnw}, 2'b00);
    tick();

    // R9 clear, R7 decrement borrow
    apply(16'h0028, 16'h0000);
    tick();
    chk("R9 clear", {idx_y_q, reg_zero[2], reg_carry[2]}, {16'h0000, 2'b10});
    apply(16'h0018, 16'h0000);
    tick();
    chk("R7 dec borrow", {idx_y_q, reg_zero[2], reg_carry[2]}, {16'hFFFF, 2'b01});

    // R10 pc load via stack pop
    apply(16'h3001, 16'h0100);
    chk("R11 pop addr2", mem_addr, 16'h0002);
    tick();
    chk("R10 pc load", pc_q, 16'h0100);
    chk("R11 sp inc", sp_q, 16'h0003);

    // R11 stack load from X, then drive
    apply(16'h0043, 16'hBEEF);
    chk("R11 load bus", int_bus, 16'h0011);
    tick();
    chk("R11 sp load", sp_q, 16'h0011);
    apply(16'h0004, 16'hBEEF);
    chk("R11 sp drive", {int_bus, mem_vma, mem_rnw}, {16'h0011, 2'b00});
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule